// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block holds the trial register and the sequencing logic of an N-bit successive approximation converter. A start request received while the block is idle begins a binary search. The current trial code drives an external DAC. An external comparator reports whether the analog input exceeds the DAC output. On every clock the controller settles one bit, working from the most significant bit to the least significant. Because of this, a conversion always takes exactly N clocks, whatever the input.

Once the least significant bit is settled, the final code goes to a result register and a one-clock done pulse is raised. The result register keeps its value until the next conversion completes. Start requests that arrive during a conversion have no effect.

Top module: `sar_core`

## Requirements
- R1: While reset is held and after it is released, `result`, `dacCode`, `done` and `busy` are all zero until a start is accepted.
- R2: A `startReq` sampled high while idle sets `busy`. On the following cycle `dacCode` holds only the most significant bit set (value 2^(N-1)).
- R3: At each decision clock, the bit under trial is kept at 1 if `cmpHigh` is 1 and cleared to 0 if `cmpHigh` is 0. All bits above it are unchanged.
- R4: After a non-final bit is decided, the next lower bit is set to 1 in the same clock. Bits are tried strictly from the most significant down to the least significant.
- R5: `done` rises exactly N clocks after the clock edge that accepted the start, for every input value.
- R6: `done` is high for exactly one cycle. `busy` falls on the same edge that raises `done`.
- R7: `result` changes only on the edge that raises `done`, and it then equals the final trial code. At all other times it stays stable.
- R8: A `startReq` sampled while `busy` is high has no effect on the trial sequence, the latency or the result.
- R9: With N=6, one code step per volt and a 37.4 V input, the codes presented on `dacCode` are 32, 48, 40, 36, 38, 37, and the result is 37.
- R10: A start presented during the cycle that `done` is high is accepted, so conversions can run back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin a conversion (used only when idle) |
| cmpHigh | input | 1 | Comparator: 1 when the analog input exceeds the DAC output |
| dacCode | output | WIDTH | Current trial code driven to the DAC |
| result | output | WIDTH | Code from the last completed conversion |
| done | output | 1 | One-cycle pulse when a conversion completes |
| busy | output | 1 | High while a conversion is in progress |

## Verification
The bench targets the input extremes: zero input, where every trial bit is cleared, and inputs at or above full scale, where every trial bit is kept. A design with an inverted keep/clear rule, or with an off-by-one pointer, would return a wrong code at one of these ends, or a latency other than N. Start requests are repeated mid-conversion and issued in the same cycle as `done`. A controller that restarts while busy would cut the search short and give a wrong code. A controller that needs an idle gap would miss the back-to-back start. Every cycle, the result register is compared against a behavioural model, so an early or late update of `result` shows up as a mismatch.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Strobes from the sequencer to the trial/result datapath
  typedef struct packed {
    logic load;    // start accepted: seed the trial register
    logic decide;  // settle the bit under trial this clock
    logic finish;  // this decision is the last one
  } sarStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       lastBit,
  output sarStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  typedef enum logic {ST_IDLE, ST_CONV} state_t;
  state_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startReq) begin
        strobe.load = 1'b1;
        stateNext   = ST_CONV;
      end
      ST_CONV: begin
        strobe.decide = 1'b1;
        if (lastBit) begin
          strobe.finish = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.finish;
    end
  end

  assign busy = (state == ST_CONV);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lastBit |=> busy);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> busy);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  sarStrobe_t   strobe,
  input  logic         cmpHigh,
  output logic [W-1:0] trialCode,
  output logic [W-1:0] resultCode,
  output logic         lastBit
);
  localparam logic [W-1:0] TOP_ONE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] ptr;        // one-hot marker of the bit under trial
  logic [W-1:0] ptrNext;
  logic [W-1:0] trialNext;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic IS_TOP = (i == W - 1);
    logic setNext;
    if (i == W - 1) begin : g_top
      assign setNext = 1'b0;
    end else begin : g_low
      assign setNext = ptr[i+1];
    end
    assign trialNext[i] = strobe.load   ? IS_TOP :
                          strobe.decide ? (ptr[i] ? cmpHigh : (trialCode[i] | setNext)) :
                          trialCode[i];
  end

  assign ptrNext = strobe.load   ? TOP_ONE :
                   strobe.decide ? (ptr >> 1) : ptr;
  assign lastBit = ptr[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr        <= '0;
      trialCode  <= '0;
      resultCode <= '0;
    end else begin
      ptr       <= ptrNext;
      trialCode <= trialNext;
      if (strobe.finish) resultCode <= trialNext;
    end
  end

  assert_ptr_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ptr));
  assert_seed_msb_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> trialCode == TOP_ONE);
  assert_keep_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide && cmpHigh |=> (trialCode & $past(ptr)) != '0);
  assert_clear_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide && !cmpHigh |=> (trialCode & $past(ptr)) == '0);
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(resultCode));
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result,
  output logic             done,
  output logic             busy
);
  sarStrobe_t strobe;
  logic       lastBit;

  sar_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lastBit(lastBit),
    .strobe(strobe), .busy(busy), .done(done)
  );

  sar_datapath #(.W(WIDTH)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpHigh(cmpHigh),
    .trialCode(dacCode), .resultCode(result), .lastBit(lastBit)
  );
endmodule

// File: tb/test_sar_core.sv
module test_sar_core;
  localparam int CLK_PERIOD = 10;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic cmpHigh;
  logic [W-1:0] dacCode, result;
  logic done, busy;
  int ain10 = 0;          // analog input in tenths of a code step
  int nChecks = 0, nFails = 0, cycles = 0;
  bit modelOn = 1'b0;

  // Behavioural model state
  int mTrial = 0, mIdx = 0, mResult = 0;
  bit mBusy = 0, mDone = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // DAC + comparator model
  assign cmpHigh = ain10 > int'(dacCode) * 10;

  sar_core #(.WIDTH(W)) i_sar_core (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .result(result), .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: binary search over integers, one bit per clock
  always @(posedge clk) begin
    if (!rstN) begin
      mTrial = 0; mIdx = 0; mResult = 0; mBusy = 0; mDone = 0;
    end else begin
      mDone = 0;
      if (!mBusy) begin
        if (startReq) begin
          mIdx = W - 1; mTrial = 1 << mIdx; mBusy = 1;
        end
      end else begin
        if (!(ain10 > mTrial * 10)) mTrial = mTrial & ~(1 << mIdx);
        if (mIdx == 0) begin
          mResult = mTrial; mDone = 1; mBusy = 0;
        end else begin
          mIdx = mIdx - 1; mTrial = mTrial | (1 << mIdx);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      check(int'(dacCode) == mTrial, "R4 dacCode vs model", dacCode, mTrial);
      check(int'(result) == mResult, "R7 result vs model", result, mResult);
      check(done == mDone, "R6 done vs model", done, mDone);
      check(busy == mBusy, "R8 busy vs model", busy, mBusy);
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        finishRun();
      end
    end
  end

  // Start a conversion and wait for done; returns latency and optionally pokes start mid-run
  task automatic convert(input int a10, input int expCode, input bit pokeBusy, input string tag);
    int lat;
    ain10 = a10;
    startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    lat = 0;
    while (!done && lat < 50) begin
      if (pokeBusy && (lat == 1 || lat == 3)) startReq = 1'b1;
      else startReq = 1'b0;
      @(negedge clk);
      lat++;
    end
    startReq = 1'b0;
    check(lat == W, {tag, " R5 latency"}, lat, W);
    check(int'(result) == expCode, {tag, " R3 result"}, result, expCode);
    check(!busy, {tag, " R6 busy low at done"}, busy, 0);
    @(negedge clk);
    check(!done, {tag, " R6 done single pulse"}, done, 0);
  endtask

  initial begin
    int expSeq[6] = '{32, 48, 40, 36, 38, 37};
    repeat (3) @(negedge clk);
    check(result == 0 && dacCode == 0, "R1 reset codes", result, 0);
    check(!done && !busy, "R1 reset flags", {done, busy}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(result == 0 && dacCode == 0 && !busy, "R1 after release", result, 0);
    modelOn = 1'b1;

    // R9 worked example: 37.4 V
    ain10 = 374;
    startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(int'(dacCode) == 32, "R2 seed code", dacCode, 32);
    for (int k = 0; k < 6; k++) begin
      check(int'(dacCode) == expSeq[k], "R9 trial sequence", dacCode, expSeq[k]);
      check(int'(result) == 0, "R7 result held during run", result, 0);
      @(negedge clk);
    end
    check(done == 1'b1, "R5 done after N clocks", done, 1);
    check(int'(result) == 37, "R9 final code", result, 37);

    // R10 back-to-back start in the done cycle
    ain10 = 0;
    startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1 && int'(dacCode) == 32, "R10 restart in done cycle", dacCode, 32);
    check(int'(result) == 37, "R7 result kept across restart", result, 37);
    repeat (W) @(negedge clk);
    check(int'(result) == 0, "R3 zero input clears every bit", result, 0);
    @(negedge clk);

    convert(9999, 63, 1'b0, "full scale");
    convert(639, 63, 1'b0, "just below top");
    convert(10, 0, 1'b0, "exact one step");
    convert(11, 1, 1'b0, "just above one step");
    convert(215, 21, 1'b1, "R8 start while busy");
    convert(501, 50, 1'b1, "R8 start while busy 2");
    convert(320, 31, 1'b0, "mid boundary");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule